// File: doc/BRIEF.md
# Configurable Register Macrocell

This block is one programmable logic cell. It takes a single sum-of-products term and turns it into the cell's output. A static configuration sets the behaviour. The storage element can act as a D flip-flop or a T flip-flop, or it can be bypassed so the term passes straight through. The register clock comes from one of six sources: four global clocks, or two local control terms. A global clock can trigger on either edge. Two control terms give an asynchronous preset and clear, and a per-cell bit can turn these off. A power-on reset clears the register.

The output stage picks its enable from four control terms, or holds it always on or always off. A global active-low 3-state input, when armed, forces the enable off on top of the local choice. The pin is modelled without real tri-states. The cell reports the value it drives and its enable. It also returns two feedback signals to the interconnect. The cell feedback is taken ahead of the buffer. The pin feedback is taken after the buffer, so it carries the external value whenever the cell is not driving.

The configuration inputs are treated as static straps. They may change only while power-on reset is held low.

Top module: `cfg_macrocell`

## Requirements
- R1: With `cfg_mode`=0 (D), a rising edge on the effective clock loads the value of `sop` into the register, and `fb_cell` shows the register.
- R2: With `cfg_mode`=1 (T), an effective clock edge inverts the register when `sop` is 1 and keeps it when `sop` is 0.
- R3: With `cfg_mode`=2 or 3 (bypass), `fb_cell` and `pin_q` follow `sop` combinationally, with no clock needed.
- R4: `cfg_clk_sel` values 0 to 3 select `gclk[0]` to `gclk[3]`, 4 selects `ct[2]` and 5 selects `ct[3]`. Values 6 and 7 select no clock. Edges on sources that are not selected leave the register unchanged.
- R5: When a global clock is selected, `cfg_fall`=1 moves capture to its falling edge. `cfg_fall` has no effect when a control-term clock is selected.
- R6: With `cfg_init_en`=1, a high `ct[0]` sets the register to 1 at once, without waiting for a clock, and holds it there while high.
- R7: With `cfg_init_en`=1, a high `ct[1]` clears the register to 0 at once. It wins over `ct[0]` and over any clock edge.
- R8: With `cfg_init_en`=0, `ct[0]` and `ct[1]` have no effect on the register.
- R9: While `por_n` is low, the register is 0, independent of clocks and control terms.
- R10: `cfg_oe_sel` values 0 to 3 take the enable from `ct[2]` to `ct[5]`, 4 holds it on, and 5 to 7 hold it off.
- R11: When `cfg_gts_en`=1 and `gts_n`=0, `pin_oe` is 0 whatever the selected enable. When either condition is absent, the local enable applies.
- R12: `fb_pin` equals `pin_q` while `pin_oe` is 1 and equals `ext_in` while `pin_oe` is 0. `fb_cell` never depends on the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| gclk | input | 4 | Global clock lines |
| ct | input | 6 | Control terms: 0 preset, 1 clear, 2-3 local clocks and enables, 4-5 enables |
| sop | input | 1 | Sum-of-products input term |
| gts_n | input | 1 | Global 3-state, active low |
| ext_in | input | 1 | Value driven onto the pin from outside |
| cfg_mode | input | 2 | Storage mode: 0 D, 1 T, 2/3 bypass |
| cfg_clk_sel | input | 3 | Clock source select |
| cfg_fall | input | 1 | Falling-edge capture for global clocks |
| cfg_init_en | input | 1 | Enables asynchronous preset and clear |
| cfg_oe_sel | input | 3 | Output-enable source select |
| cfg_gts_en | input | 1 | Arms the global 3-state input |
| pin_q | output | 1 | Value the cell drives toward the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_cell | output | 1 | Feedback taken ahead of the output buffer |
| fb_pin | output | 1 | Feedback taken from the pin |

## Verification
The checker samples on rising edges of `gclk[0]`. It relies on the control terms, `ext_in` and `gts_n` being steady levels that change only well away from those edges. The bench drives data-type inputs first and clock-type inputs two nanoseconds later. Each level is held for a full step, so a preset or clear is always visible at a sample point. Configuration changes only under power-on reset, and the checker is disabled during that reset, so no property sees a half-applied configuration.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

   typedef enum logic [1:0] {
      MC_DFF    = 2'd0,
      MC_TFF    = 2'd1,
      MC_BYPASS = 2'd2
   } mc_mode_e;

   function automatic logic mode_is_bypass(input logic [1:0] m);
      return m[1];
   endfunction

   function automatic logic mode_is_toggle(input logic [1:0] m);
      return (m == MC_TFF);
   endfunction

endpackage

// File: rtl/mcell_clksel.sv
module mcell_clksel #(
   parameter int GCLK_N = 4,
   parameter int LCLK_N = 2,
   parameter int SEL_W  = 3
) (
   input  logic [GCLK_N-1:0] gclk,
   input  logic [LCLK_N-1:0] lclk,
   input  logic [SEL_W-1:0]  sel,
   input  logic              fall,
   output logic              clk_o
);
   localparam int SRC_N = GCLK_N + LCLK_N;

   logic [SRC_N-1:0] src;

   // global lines take the edge choice, local terms are used as they are
   for (genvar g = 0; g < GCLK_N; g++) begin : g_glob
      assign src[g] = gclk[g] ^ fall;
   end
   for (genvar l = 0; l < LCLK_N; l++) begin : g_loc
      assign src[GCLK_N+l] = lclk[l];
   end

   always_comb begin
      clk_o = 1'b0;
      for (int i = 0; i < SRC_N; i++) begin
         if (sel == SEL_W'(i)) clk_o = src[i];
      end
   end
endmodule

// File: rtl/mcell_store.sv
module mcell_store #(
   parameter bit HAS_TOGGLE = 1'b1
) (
   input  logic       clk_i,
   input  logic       por_n,
   input  logic       init_en,
   input  logic       set_i,
   input  logic       clr_i,
   input  logic [1:0] mode,
   input  logic       d_i,
   output logic       q_o
);
   import mcell_pkg::*;

   logic rst_a;
   logic set_a;
   logic nxt;

   assign rst_a = ~por_n | (init_en & clr_i);
   assign set_a = init_en & set_i;

   if (HAS_TOGGLE) begin : g_dt
      always_comb nxt = mode_is_toggle(mode) ? (q_o ^ d_i) : d_i;
   end else begin : g_d_only
      always_comb nxt = d_i;
   end

   always_ff @(posedge clk_i or posedge rst_a or posedge set_a) begin
      if (rst_a)      q_o <= 1'b0;
      else if (set_a) q_o <= 1'b1;
      else            q_o <= nxt;
   end
endmodule

// File: rtl/mcell_oe.sv
module mcell_oe #(
   parameter int TERM_N = 4,
   parameter int SEL_W  = 3
) (
   input  logic [TERM_N-1:0] terms,
   input  logic [SEL_W-1:0]  sel,
   input  logic              gts_en,
   input  logic              gts_n,
   output logic              oe_o
);
   logic local_oe;

   always_comb begin
      local_oe = 1'b0;
      for (int i = 0; i < TERM_N; i++) begin
         if (sel == SEL_W'(i)) local_oe = terms[i];
      end
      if (sel == SEL_W'(TERM_N)) local_oe = 1'b1;
   end

   assign oe_o = local_oe & ~(gts_en & ~gts_n);
endmodule

// File: rtl/mcell_pin.sv
module mcell_pin (
   input  logic drv_i,
   input  logic oe_i,
   input  logic ext_i,
   output logic pin_q,
   output logic pin_oe,
   output logic fb_pin
);
   assign pin_q  = drv_i;
   assign pin_oe = oe_i;
   assign fb_pin = oe_i ? drv_i : ext_i;
endmodule

// File: rtl/cfg_macrocell.sv
module cfg_macrocell #(
   parameter int GCLK_N     = 4,
   parameter int LCLK_N     = 2,
   parameter int OE_TERM_N  = 4,
   parameter int CT_N       = 6,
   parameter int CT_PRE     = 0,
   parameter int CT_CLR     = 1,
   parameter int CT_LCLK0   = 2,
   parameter int CT_OE0     = 2,
   parameter bit HAS_TOGGLE = 1'b1,
   localparam int CLK_SEL_W = $clog2(GCLK_N + LCLK_N + 1),
   localparam int OE_SEL_W  = $clog2(OE_TERM_N + 2)
) (
   input  logic                 por_n,
   input  logic [GCLK_N-1:0]    gclk,
   input  logic [CT_N-1:0]      ct,
   input  logic                 sop,
   input  logic                 gts_n,
   input  logic                 ext_in,
   input  logic [1:0]           cfg_mode,
   input  logic [CLK_SEL_W-1:0] cfg_clk_sel,
   input  logic                 cfg_fall,
   input  logic                 cfg_init_en,
   input  logic [OE_SEL_W-1:0]  cfg_oe_sel,
   input  logic                 cfg_gts_en,
   output logic                 pin_q,
   output logic                 pin_oe,
   output logic                 fb_cell,
   output logic                 fb_pin
);
   import mcell_pkg::*;

   if (GCLK_N < 1) begin : g_bad_gclk
      $error("cfg_macrocell: GCLK_N must be at least 1");
   end
   if (CT_LCLK0 + LCLK_N > CT_N) begin : g_bad_lclk
      $error("cfg_macrocell: local clock terms exceed CT_N");
   end
   if (CT_OE0 + OE_TERM_N > CT_N) begin : g_bad_oe
      $error("cfg_macrocell: enable terms exceed CT_N");
   end
   if (CT_PRE == CT_CLR || CT_PRE >= CT_N || CT_CLR >= CT_N) begin : g_bad_init
      $error("cfg_macrocell: preset/clear term indices invalid");
   end

   logic clk_eff;
   logic q_reg;
   logic cell_out;
   logic oe_eff;

   mcell_clksel #(
      .GCLK_N (GCLK_N),
      .LCLK_N (LCLK_N),
      .SEL_W  (CLK_SEL_W)
   ) u_clksel (
      .gclk  (gclk),
      .lclk  (ct[CT_LCLK0 +: LCLK_N]),
      .sel   (cfg_clk_sel),
      .fall  (cfg_fall),
      .clk_o (clk_eff)
   );

   mcell_store #(
      .HAS_TOGGLE (HAS_TOGGLE)
   ) u_store (
      .clk_i   (clk_eff),
      .por_n   (por_n),
      .init_en (cfg_init_en),
      .set_i   (ct[CT_PRE]),
      .clr_i   (ct[CT_CLR]),
      .mode    (cfg_mode),
      .d_i     (sop),
      .q_o     (q_reg)
   );

   assign cell_out = mode_is_bypass(cfg_mode) ? sop : q_reg;
   assign fb_cell  = cell_out;

   mcell_oe #(
      .TERM_N (OE_TERM_N),
      .SEL_W  (OE_SEL_W)
   ) u_oe (
      .terms  (ct[CT_OE0 +: OE_TERM_N]),
      .sel    (cfg_oe_sel),
      .gts_en (cfg_gts_en),
      .gts_n  (gts_n),
      .oe_o   (oe_eff)
   );

   mcell_pin u_pin (
      .drv_i  (cell_out),
      .oe_i   (oe_eff),
      .ext_i  (ext_in),
      .pin_q  (pin_q),
      .pin_oe (pin_oe),
      .fb_pin (fb_pin)
   );
endmodule

// File: rtl/mcell_chk.sv
module mcell_chk (
   input logic       sclk,
   input logic       por_n,
   input logic       ct_pre,
   input logic       ct_clr,
   input logic       cfg_init_en,
   input logic       cfg_gts_en,
   input logic       gts_n,
   input logic [1:0] cfg_mode,
   input logic       sop,
   input logic       q_reg,
   input logic       fb_cell,
   input logic       pin_q,
   input logic       pin_oe,
   input logic       fb_pin,
   input logic       ext_in
);
   // R7: clear holds the register low, also against preset
   a_r7_clear_wins: assert property (@(posedge sclk) disable iff (!por_n)
      (cfg_init_en && ct_clr) |-> !q_reg);

   // R6: preset alone holds the register high
   a_r6_preset_sets: assert property (@(posedge sclk) disable iff (!por_n)
      (cfg_init_en && ct_pre && !ct_clr) |-> q_reg);

   // R11: armed global 3-state keeps the driver off
   a_r11_gts_off: assert property (@(posedge sclk) disable iff (!por_n)
      (cfg_gts_en && !gts_n) |-> !pin_oe);

   // R12: pin feedback follows the driver while enabled
   a_r12_fb_driven: assert property (@(posedge sclk) disable iff (!por_n)
      pin_oe |-> (fb_pin == pin_q));

   // R12: pin feedback follows the outside value while released
   a_r12_fb_released: assert property (@(posedge sclk) disable iff (!por_n)
      !pin_oe |-> (fb_pin == ext_in));

   // R3: bypass mode passes the term through
   a_r3_bypass: assert property (@(posedge sclk) disable iff (!por_n)
      cfg_mode[1] |-> (fb_cell == sop));
endmodule

bind cfg_macrocell mcell_chk i_chk (
   .sclk        (gclk[0]),
   .por_n       (por_n),
   .ct_pre      (ct[CT_PRE]),
   .ct_clr      (ct[CT_CLR]),
   .cfg_init_en (cfg_init_en),
   .cfg_gts_en  (cfg_gts_en),
   .gts_n       (gts_n),
   .cfg_mode    (cfg_mode),
   .sop         (sop),
   .q_reg       (q_reg),
   .fb_cell     (fb_cell),
   .pin_q       (pin_q),
   .pin_oe      (pin_oe),
   .fb_pin      (fb_pin),
   .ext_in      (ext_in)
);

// File: tb/test_cfg_macrocell.sv
module test_cfg_macrocell;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic [3:0] gclk = '0;
   logic [5:0] ct = '0;
   logic       sop = 1'b0;
   logic       gts_n = 1'b1;
   logic       ext_in = 1'b0;
   logic [1:0] cfg_mode = '0;
   logic [2:0] cfg_clk_sel = '0;
   logic       cfg_fall = 1'b0;
   logic       cfg_init_en = 1'b0;
   logic [2:0] cfg_oe_sel = '0;
   logic       cfg_gts_en = 1'b0;
   logic       pin_q, pin_oe, fb_cell, fb_pin;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;
   logic mq = 1'b0;

   always #5 clk = ~clk;

   cfg_macrocell i_cfg_macrocell (
      .por_n       (por_n),
      .gclk        (gclk),
      .ct          (ct),
      .sop         (sop),
      .gts_n       (gts_n),
      .ext_in      (ext_in),
      .cfg_mode    (cfg_mode),
      .cfg_clk_sel (cfg_clk_sel),
      .cfg_fall    (cfg_fall),
      .cfg_init_en (cfg_init_en),
      .cfg_oe_sel  (cfg_oe_sel),
      .cfg_gts_en  (cfg_gts_en),
      .pin_q       (pin_q),
      .pin_oe      (pin_oe),
      .fb_cell     (fb_cell),
      .fb_pin      (fb_pin)
   );

   function automatic logic eff_clk(input logic [3:0] g, input logic [5:0] c,
                                    input logic [2:0] s, input logic f);
      case (s)
         3'd0, 3'd1, 3'd2, 3'd3: return g[s[1:0]] ^ f;
         3'd4:    return c[2];
         3'd5:    return c[3];
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic exp_oe();
      logic o;
      case (cfg_oe_sel)
         3'd0: o = ct[2];
         3'd1: o = ct[3];
         3'd2: o = ct[4];
         3'd3: o = ct[5];
         3'd4: o = 1'b1;
         default: o = 1'b0;
      endcase
      if (cfg_gts_en && !gts_n) o = 1'b0;
      return o;
   endfunction

   task automatic check(input string tag);
      logic eo, eoe, efb;
      eo  = cfg_mode[1] ? sop : mq;
      eoe = exp_oe();
      efb = eoe ? eo : ext_in;
      n_chk++;
      if ({fb_cell, pin_q, pin_oe, fb_pin} !== {eo, eo, eoe, efb}) begin
         n_bad++;
         $display("FAIL %s: {fb_cell,pin_q,pin_oe,fb_pin} actual=%b expected=%b",
                  tag, {fb_cell, pin_q, pin_oe, fb_pin}, {eo, eo, eoe, efb});
      end
   endtask

   // data-type inputs first, clock-type inputs 2 ns later, compare 3 ns after that
   task automatic step(input logic s, input logic [5:0] c, input logic [3:0] g,
                       input logic e, input logic gn, input string tag);
      logic pc, nc;
      @(posedge clk); #2;
      pc = eff_clk(gclk, ct, cfg_clk_sel, cfg_fall);
      sop = s; ct[0] = c[0]; ct[1] = c[1]; ct[4] = c[4]; ct[5] = c[5];
      ext_in = e; gts_n = gn;
      if (!por_n || (cfg_init_en && ct[1])) mq = 1'b0;
      else if (cfg_init_en && ct[0])       mq = 1'b1;
      #2;
      gclk = g; ct[2] = c[2]; ct[3] = c[3];
      nc = eff_clk(gclk, ct, cfg_clk_sel, cfg_fall);
      if (!por_n || (cfg_init_en && ct[1])) mq = 1'b0;
      else if (cfg_init_en && ct[0])       mq = 1'b1;
      else if (!pc && nc)                  mq = (cfg_mode == 2'd1) ? (mq ^ sop) : sop;
      #3;
      check(tag);
   endtask

   task automatic setup(input logic [1:0] m, input logic [2:0] cs, input logic f,
                        input logic ie, input logic [2:0] os, input logic ge);
      @(posedge clk); #2;
      por_n = 1'b0;
      sop = 1'b0; ct = '0; gclk = '0; ext_in = 1'b0; gts_n = 1'b1;
      cfg_mode = m; cfg_clk_sel = cs; cfg_fall = f; cfg_init_en = ie;
      cfg_oe_sel = os; cfg_gts_en = ge;
      mq = 1'b0;
      #5; check("R9 reset state");
      @(posedge clk); #2;
      por_n = 1'b1;
      #5; check("R9 after release");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R1..: actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      // R1 D mode on gclk[0] rising edge, R4 other lines ignored
      setup(2'd0, 3'd0, 1'b0, 1'b0, 3'd4, 1'b0);
      step(1, 6'h00, 4'b0001, 0, 1, "R1 capture 1");
      step(0, 6'h00, 4'b0000, 0, 1, "R1 no edge");
      step(0, 6'h00, 4'b0001, 0, 1, "R1 capture 0");
      step(1, 6'h00, 4'b1110, 0, 1, "R4 unselected globals");
      step(1, 6'h0C, 4'b0001, 0, 1, "R4 unselected terms");
      step(0, 6'h00, 4'b0000, 0, 1, "R1 falling edge ignored");
      // R5 falling edge on gclk[1]
      setup(2'd0, 3'd1, 1'b1, 1'b0, 3'd4, 1'b0);
      step(1, 6'h00, 4'b0010, 0, 1, "R5 rise ignored");
      step(1, 6'h00, 4'b0000, 0, 1, "R5 fall captures");
      step(0, 6'h00, 4'b0010, 0, 1, "R5 rise ignored");
      step(0, 6'h00, 4'b0000, 0, 1, "R5 fall captures 0");
      // R5 edge choice ignored on term clock, R4 term ct[2]
      setup(2'd0, 3'd4, 1'b1, 1'b0, 3'd5, 1'b0);
      step(1, 6'h00, 4'b1111, 0, 1, "R4 globals ignored");
      step(1, 6'h04, 4'b0000, 0, 1, "R5 term rises captures");
      step(0, 6'h00, 4'b0000, 0, 1, "R5 term fall ignored");
      // R4 term ct[3]
      setup(2'd0, 3'd5, 1'b0, 1'b0, 3'd5, 1'b0);
      step(1, 6'h04, 4'b0000, 0, 1, "R4 ct2 ignored");
      step(1, 6'h08, 4'b0000, 0, 1, "R4 ct3 captures");
      step(0, 6'h00, 4'b0000, 0, 1, "R4 ct3 low");
      step(0, 6'h08, 4'b0000, 0, 1, "R4 ct3 captures 0");
      // R4 no-clock select
      setup(2'd0, 3'd7, 1'b0, 1'b0, 3'd4, 1'b0);
      step(1, 6'h0C, 4'b1111, 0, 1, "R4 no source");
      // R2 toggle on gclk[2]
      setup(2'd1, 3'd2, 1'b0, 1'b0, 3'd4, 1'b0);
      step(1, 6'h00, 4'b0100, 0, 1, "R2 toggle up");
      step(1, 6'h00, 4'b0000, 0, 1, "R2 low phase");
      step(0, 6'h00, 4'b0100, 0, 1, "R2 hold");
      step(1, 6'h00, 4'b0000, 0, 1, "R2 low phase");
      step(1, 6'h00, 4'b0100, 0, 1, "R2 toggle down");
      step(1, 6'h00, 4'b0000, 0, 1, "R2 low phase");
      step(1, 6'h00, 4'b0100, 0, 1, "R2 toggle up again");
      // R3 bypass
      setup(2'd2, 3'd0, 1'b0, 1'b0, 3'd4, 1'b0);
      step(1, 6'h00, 4'b0000, 0, 1, "R3 pass 1");
      step(0, 6'h00, 4'b0000, 0, 1, "R3 pass 0");
      setup(2'd3, 3'd0, 1'b0, 1'b0, 3'd4, 1'b0);
      step(1, 6'h00, 4'b0001, 0, 1, "R3 mode 3 pass");
      // R6 / R7 asynchronous init
      setup(2'd0, 3'd0, 1'b0, 1'b1, 3'd4, 1'b0);
      step(0, 6'h01, 4'b0000, 0, 1, "R6 preset");
      step(0, 6'h01, 4'b0001, 0, 1, "R6 preset beats edge");
      step(0, 6'h00, 4'b0000, 0, 1, "R6 held after release");
      step(1, 6'h02, 4'b0001, 0, 1, "R7 clear beats edge");
      step(1, 6'h03, 4'b0000, 0, 1, "R7 clear beats preset");
      step(1, 6'h00, 4'b0001, 0, 1, "R7 released, edge loads");
      step(0, 6'h02, 4'b0000, 0, 1, "R7 clear");
      // R8 init disabled
      setup(2'd0, 3'd0, 1'b0, 1'b0, 3'd4, 1'b0);
      step(0, 6'h01, 4'b0000, 0, 1, "R8 preset ignored");
      step(1, 6'h00, 4'b0001, 0, 1, "R8 load 1");
      step(1, 6'h02, 4'b0000, 0, 1, "R8 clear ignored");
      // R9 power-on reset mid-run
      setup(2'd0, 3'd0, 1'b0, 1'b0, 3'd4, 1'b0);
      step(1, 6'h00, 4'b0001, 0, 1, "R9 load before reset");
      setup(2'd0, 3'd0, 1'b0, 1'b0, 3'd4, 1'b0);
      // R10 every enable source
      for (int k = 0; k < 8; k++) begin
         setup(2'd2, 3'd7, 1'b0, 1'b0, 3'(k), 1'b0);
         step(1, 6'h3C, 4'b0000, 0, 1, "R10 terms high");
         step(1, 6'h00, 4'b0000, 0, 1, "R10 terms low");
         step(1, 6'h14, 4'b0000, 0, 1, "R10 mixed a");
         step(1, 6'h28, 4'b0000, 0, 1, "R10 mixed b");
      end
      // R11 global 3-state combinations
      for (int ge = 0; ge < 2; ge++) begin
         setup(2'd2, 3'd7, 1'b0, 1'b0, 3'd4, 1'(ge));
         step(1, 6'h00, 4'b0000, 0, 1, "R11 gts high");
         step(1, 6'h00, 4'b0000, 0, 0, "R11 gts low");
         step(0, 6'h00, 4'b0000, 1, 0, "R11 gts low ext 1");
      end
      // R12 pin feedback
      setup(2'd2, 3'd7, 1'b0, 1'b0, 3'd5, 1'b0);
      step(0, 6'h00, 4'b0000, 1, 1, "R12 released ext 1");
      step(1, 6'h00, 4'b0000, 0, 1, "R12 released ext 0");
      setup(2'd2, 3'd7, 1'b0, 1'b0, 3'd4, 1'b0);
      step(1, 6'h00, 4'b0000, 0, 1, "R12 driven 1 ext 0");
      step(0, 6'h00, 4'b0000, 1, 1, "R12 driven 0 ext 1");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule